// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers every interrupt and exception request in a small CPU subsystem and decides which one the CPU services next. It handles sixteen hardware request lines, two software exceptions (a software-interrupt instruction and an illegal-opcode trap) and three system faults: a system reset request, a clock-monitor failure and a watchdog failure. Each source owns a fixed two-byte vector slot near the top of the 64 KiB address space. The source with the highest slot number always wins.

Maskable sources need their own enable bit and a clear global mask. Non-maskable sources ignore both. When a request wins, the block raises a pending flag and registers the winner's slot index and the address of its vector's high byte. The low byte sits at the next address. The outputs hold still until the CPU acknowledges. Edge-type sources are latched and cleared by that acknowledge. Level-type sources follow their request line.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `irq_pend`, `irq_idx` and `vec_addr` are all zero.
- R2: A pending request at slot s gives `irq_idx` = s and `vec_addr` = 0xFFC0 + 2*s. `hw_req` bit k uses slot 11+k, so bit 0 is slot 11 (0xFFD6) and bit 15 is slot 26 (0xFFF4). The other sources use these slots: `swi_req` 27, `illop_req` 28, `wdog_fail` 29, `clkmon_fail` 30, `sysrst_req` 31.
- R3: While `irq_pend` is high, `irq_idx` is never below 11. The reserved slots 0 to 10 are never presented.
- R4: `hw_req` bits 0 to 14 are maskable. Each one wins only when its `hw_en` bit is 1 and `gmask` is 0.
- R5: `hw_req[15]`, `swi_req`, `illop_req`, `wdog_fail`, `clkmon_fail` and `sysrst_req` are non-maskable. They are presented whatever `gmask` and `hw_en` hold.
- R6: When several eligible requests are present, the one with the highest slot is presented.
- R7: While `irq_pend` is high and `ack` is low, `irq_idx` and `vec_addr` stay unchanged, even if a higher-priority request arrives.
- R8: `ack` sampled high while `irq_pend` is high drops `irq_pend` on the next cycle. The block re-arbitrates on the cycle after that.
- R9: An edge-type source is latched on the rising edge of its line. Acknowledging that source clears the latch. A line still held high does not fire again. Every source except `hw_req[14]` and `hw_req[15]` is edge-type.
- R10: `hw_req[14]` and `hw_req[15]` are level-type. They request only while their line is high, so they fire again after an acknowledge if the line is still high. A level pulse that ends while blocked is not remembered.
- R11: `ack` sampled while `irq_pend` is low has no effect, and no latched request is lost.
- R12: An edge request latched while masked is presented once its masking is lifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req | input | 16 | Hardware request lines, bit k at slot 11+k |
| hw_en | input | 16 | Per-line enables (bit 15 unused) |
| gmask | input | 1 | Global mask for maskable sources, 1 = blocked |
| swi_req | input | 1 | Software-interrupt instruction request |
| illop_req | input | 1 | Illegal-opcode trap request |
| wdog_fail | input | 1 | Watchdog failure |
| clkmon_fail | input | 1 | Clock-monitor failure |
| sysrst_req | input | 1 | System reset request |
| ack | input | 1 | CPU acknowledge of the presented request |
| irq_pend | output | 1 | A request is being presented |
| irq_idx | output | 5 | Slot index of the presented request |
| vec_addr | output | 16 | Address of the vector's high byte |

## Verification
The bench raises low, middle and high slots in the same cycle and then acknowledges them one after another. A wrong priority encoder shows up as the wrong order of indices. It also raises a higher request while a lower one is already presented. A design that re-arbitrates before the acknowledge would change `vec_addr` there.

Edge and level handling are tested separately. An edge line held through its acknowledge must not fire again, while a held level line must. A masked edge must survive both an idle acknowledge and the later unmasking. A bad latch clear would either lose that request or repeat it without end.

// File: rtl/vic_pkg.sv
// Package: shared widths and slot-map constants for the vectored interrupt controller.
// Assumes a 16-bit address space with two-byte vectors ending at the top.
package vic_pkg;
    localparam int ADDR_W     = 16;
    localparam int SLOT_W     = 5;
    localparam int FIRST_SLOT = 11;
    localparam logic [ADDR_W-1:0] VEC_BASE = 16'hFFC0;
    typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/vic_req_latch.sv
// Module: conditions raw request lines into pending requests.
// Edge-type bits latch on a rising edge and clear on a targeted acknowledge.
// Level-type bits pass through live. EDGE_MASK picks the type of each bit.
module vic_req_latch #(
    parameter int             NSRC      = 21,
    parameter logic [NSRC-1:0] EDGE_MASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raw,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            logic prev_q;
            logic held_q;
            // Remember the line and latch a rising edge; a new edge beats a clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                    held_q <= 1'b0;
                end else begin
                    prev_q <= raw[i];
                    if (raw[i] && !prev_q) held_q <= 1'b1;
                    else if (clr[i])       held_q <= 1'b0;
                end
            end
            assign pend[i] = held_q;
        end else begin : g_level
            // A level source requests for as long as its line is high.
            assign pend[i] = raw[i];
        end
    end
endmodule

// File: rtl/vic_prio_pick.sv
// Module: fixed-priority picker. The highest set bit of elig wins.
// Purely combinational; valid is low when nothing is eligible.
module vic_prio_pick #(
    parameter int NSRC  = 21,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  elig,
    output logic             valid,
    output logic [IDX_W-1:0] win
);
    // Scan upward so the last set bit, the highest priority, is kept.
    always_comb begin
        valid = 1'b0;
        win   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i]) begin
                valid = 1'b1;
                win   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
// Module: vectored priority interrupt controller top.
// Source order (low to high): hw_req lines, swi, illegal opcode, watchdog,
// clock monitor, system reset. Source j sits at slot FIRST_SLOT + j.
// The top hardware line and everything above it are non-maskable.
// Assumes the CPU asserts ack for one cycle per presented request.
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int HW_LINES = 16,
    localparam int NSRC    = HW_LINES + 5,
    parameter logic [NSRC-1:0] EDGE_MASK = {5'b11111, 2'b00, {(HW_LINES-2){1'b1}}}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HW_LINES-1:0] hw_req,
    input  logic [HW_LINES-1:0] hw_en,
    input  logic                gmask,
    input  logic                swi_req,
    input  logic                illop_req,
    input  logic                wdog_fail,
    input  logic                clkmon_fail,
    input  logic                sysrst_req,
    input  logic                ack,
    output logic                irq_pend,
    output logic [SLOT_W-1:0]   irq_idx,
    output logic [ADDR_W-1:0]   vec_addr
);
    localparam int IDX_W = $clog2(NSRC);
    localparam int NM_LO = HW_LINES - 1;
    localparam logic [NSRC-1:0] NMI_MASK = {{(NSRC-NM_LO){1'b1}}, {NM_LO{1'b0}}};

    logic [NSRC-1:0]  raw, pend, clr, allow, elig;
    logic             any;
    logic [IDX_W-1:0] win;
    logic [IDX_W-1:0] win_q;
    slot_t            slot;

    // Gather all sources in priority order.
    assign raw = {sysrst_req, clkmon_fail, wdog_fail, illop_req, swi_req, hw_req};

    // An acknowledge clears only the source that is being presented.
    always_comb begin
        clr = '0;
        if (irq_pend && ack) clr[win_q] = 1'b1;
    end

    vic_req_latch #(.NSRC(NSRC), .EDGE_MASK(EDGE_MASK)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw),
        .clr  (clr),
        .pend (pend)
    );

    // Maskable sources need their enable and a clear global mask.
    assign allow = NMI_MASK | ({{(NSRC-HW_LINES){1'b0}}, hw_en} & {NSRC{~gmask}});
    assign elig  = pend & allow;

    vic_prio_pick #(.NSRC(NSRC)) u_pick (
        .elig (elig),
        .valid(any),
        .win  (win)
    );

    assign slot = slot_t'(FIRST_SLOT) + slot_t'(win);

    // Capture a winner when idle; hold it until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pend <= 1'b0;
            irq_idx  <= '0;
            vec_addr <= '0;
            win_q    <= '0;
        end else if (irq_pend) begin
            if (ack) irq_pend <= 1'b0;
        end else if (any) begin
            irq_pend <= 1'b1;
            irq_idx  <= slot;
            win_q    <= win;
            vec_addr <= VEC_BASE + ADDR_W'({slot, 1'b0});
        end
    end
endmodule

// File: rtl/vic_chk.sv
// Checker: protocol properties of the controller's outputs, bound to the top.
module vic_chk #(
    parameter int FIRST_SLOT = 11,
    parameter int NM_SLOT    = 26
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ack,
    input logic       gmask,
    input logic       irq_pend,
    input logic [4:0] irq_idx,
    input logic [15:0] vec_addr
);
    // R7: a presented request holds until acknowledged
    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend && !ack |=> irq_pend && $stable(irq_idx) && $stable(vec_addr));

    // R8: acknowledge drops the pending flag on the next cycle
    a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend && ack |=> !irq_pend);

    // R3: reserved slots never presented
    a_r3_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> irq_idx >= 5'(FIRST_SLOT));

    // R4: with the global mask set, only non-maskable slots can be captured
    a_r4_gmask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend) && $past(gmask) |-> irq_idx >= 5'(NM_SLOT));

    // R2: the address of a presented request lies in the vector area
    a_r2_addr_top: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> vec_addr[15:6] == 10'h3FF && !vec_addr[0]);
endmodule

bind vec_irq_ctrl vic_chk u_vic_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (ack),
    .gmask   (gmask),
    .irq_pend(irq_pend),
    .irq_idx (irq_idx),
    .vec_addr(vec_addr)
);

// File: tb/test_vec_irq_ctrl.sv
// Bench: directed scenarios, one task each; inputs driven and outputs sampled at negedge.
module test_vec_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] hw_req, hw_en;
    logic        gmask, swi_req, illop_req, wdog_fail, clkmon_fail, sysrst_req, ack;
    logic        irq_pend;
    logic [4:0]  irq_idx;
    logic [15:0] vec_addr;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    vec_irq_ctrl i_vec_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hw_en(hw_en), .gmask(gmask),
        .swi_req(swi_req), .illop_req(illop_req), .wdog_fail(wdog_fail),
        .clkmon_fail(clkmon_fail), .sysrst_req(sysrst_req), .ack(ack),
        .irq_pend(irq_pend), .irq_idx(irq_idx), .vec_addr(vec_addr)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare the outputs with a slot expectation; slot -1 means idle.
    task automatic expect_slot(input string req, input int slot);
        logic        ep;
        logic [4:0]  ei;
        logic [15:0] ea;
        ep = (slot >= 0);
        ei = ep ? 5'(slot) : irq_idx;
        ea = ep ? 16'hFFC0 + 16'(2 * slot) : vec_addr;
        n_chk++;
        if (irq_pend !== ep || irq_idx !== ei || vec_addr !== ea) begin
            n_bad++;
            $display("FAIL %s: pend=%0b idx=%0d addr=%h expected pend=%0b idx=%0d addr=%h",
                     req, irq_pend, irq_idx, vec_addr, ep, ei, ea);
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0; hw_req = '0; hw_en = '0; gmask = 1'b0; swi_req = 1'b0;
        illop_req = 1'b0; wdog_fail = 1'b0; clkmon_fail = 1'b0; sysrst_req = 1'b0; ack = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic pulse_ack;
        ack = 1'b1; tick(1); ack = 1'b0;
    endtask

    task automatic pulse_hw(input int k);
        hw_req[k] = 1'b1; tick(1); hw_req[k] = 1'b0;
    endtask

    task automatic t_reset_state;
        do_reset;
        n_chk++;
        if (irq_pend !== 1'b0 || irq_idx !== 5'd0 || vec_addr !== 16'h0000) begin
            n_bad++;
            $display("FAIL R1: pend=%0b idx=%0d addr=%h expected 0 0 0000", irq_pend, irq_idx, vec_addr);
        end
    endtask

    task automatic t_single_edge;
        do_reset;
        hw_en[4] = 1'b1;
        hw_req[4] = 1'b1;               // held high through the acknowledge
        tick(3); expect_slot("R2", 15);
        pulse_ack; expect_slot("R8", -1);
        tick(3); expect_slot("R9", -1);
        hw_req[4] = 1'b0;
    endtask

    task automatic t_masking;
        do_reset;
        pulse_hw(4); tick(3); expect_slot("R4", -1);   // enable clear
        do_reset;
        gmask = 1'b1; hw_en[4] = 1'b1;
        pulse_hw(4); tick(3); expect_slot("R4", -1);   // global mask set
        gmask = 1'b0; tick(2); expect_slot("R12", 15);
        pulse_ack; tick(2);
    endtask

    task automatic t_non_maskable;
        do_reset;
        gmask = 1'b1;
        swi_req = 1'b1; tick(1); swi_req = 1'b0;
        tick(3); expect_slot("R5", 27);
        pulse_ack; tick(2);
        illop_req = 1'b1; tick(1); illop_req = 1'b0;
        tick(3); expect_slot("R5", 28);
        pulse_ack; tick(2);
        hw_req[15] = 1'b1; tick(3); expect_slot("R5", 26);
        hw_req[15] = 1'b0; pulse_ack; tick(3); expect_slot("R10", -1);
        wdog_fail = 1'b1; clkmon_fail = 1'b1; tick(1); wdog_fail = 1'b0; clkmon_fail = 1'b0;
        tick(3); expect_slot("R6", 30);
        pulse_ack; tick(3); expect_slot("R6", 29);
        pulse_ack; tick(3); expect_slot("R8", -1);
    endtask

    task automatic t_priority_level;
        do_reset;
        hw_en = 16'hFFFF;
        hw_req[0] = 1'b1; hw_req[9] = 1'b1; hw_req[14] = 1'b1;
        tick(1);
        hw_req[0] = 1'b0; hw_req[9] = 1'b0;
        tick(3); expect_slot("R6", 25);
        pulse_ack; tick(3); expect_slot("R10", 25);
        hw_req[14] = 1'b0;
        pulse_ack; tick(3); expect_slot("R6", 20);
        pulse_ack; tick(3); expect_slot("R6", 11);
        pulse_ack; tick(3); expect_slot("R9", -1);
    endtask

    task automatic t_hold;
        do_reset;
        hw_en[4] = 1'b1;
        pulse_hw(4); tick(3); expect_slot("R7", 15);
        swi_req = 1'b1; sysrst_req = 1'b1; tick(1); swi_req = 1'b0; sysrst_req = 1'b0;
        tick(4); expect_slot("R7", 15);
        pulse_ack; tick(3); expect_slot("R6", 31);
        pulse_ack; tick(3); expect_slot("R6", 27);
        pulse_ack; tick(3); expect_slot("R8", -1);
    endtask

    task automatic t_idle_ack;
        do_reset;
        gmask = 1'b1; hw_en[3] = 1'b1;
        pulse_hw(3); tick(2);
        pulse_ack; tick(2); expect_slot("R11", -1);
        gmask = 1'b0; tick(3); expect_slot("R11", 14);
        pulse_ack; tick(2);
        // a level pulse ending while blocked is forgotten
        gmask = 1'b1; hw_en[14] = 1'b1;
        hw_req[14] = 1'b1; tick(2); hw_req[14] = 1'b0; tick(1);
        gmask = 1'b0; tick(3); expect_slot("R10", -1);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state;
        t_single_edge;
        t_masking;
        t_non_maskable;
        t_priority_level;
        t_hold;
        t_idle_ack;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule